// File: doc/BRIEF.md
# Configuration packet stream parser

This block sits behind a byte-wide configuration port. It throws away every byte until it sees the four-byte synchronization pattern. After that it packs each group of four bytes into a 32-bit word, with the first byte as the most significant. Each word is then read either as a packet header or as a payload word of the packet in progress.

Two header kinds are understood. A type 1 header names its own target register and carries a short word count. A type 2 header carries a long word count but no address. It reuses the address of the most recent type 1 header. The block reports every decoded header as a one-cycle event. It reports every payload word with its register address and opcode attached. A malformed stream raises a sticky error flag. While that flag is set the block stops accepting bytes until the next reset.

The block does not act on register contents, check CRC or write frame memory. A downstream unit consumes the header and payload events for that.

Top module: `cfg_pkt_parser`

## Requirements
- R1: Before synchronization, accepted bytes produce no header, payload or error. Decoding begins only after the bytes 0xAA, 0x99, 0x55, 0x66 are accepted consecutively. Idle cycles between them are allowed.
- R2: After synchronization, every four accepted bytes form one word, the first of the four in bits 31:24.
- R3: The header type field is bits 31:29. Value 1 selects type 1 and value 2 selects type 2. Any other value sets the error flag and produces no header event.
- R4: A type 1 header produces a header event with hdr_is_t2=0. The event reports the opcode from bits 28:27, the address from bits 17:13 and the word count from bits 10:0, zero-extended.
- R5: A packet with word count N is followed by exactly N payload events. Each event carries the packet's address and opcode and the received word. The word after the last payload is decoded as a header.
- R6: A header with word count zero, such as 0x20000000, produces its header event and no payload. The next word is decoded as a header.
- R7: A type 2 header produces a header event with hdr_is_t2=1. The event reports the opcode from bits 28:27, the word count from bits 26:0, and the address of the most recent type 1 header.
- R8: A type 2 header received before any type 1 header since reset sets the error flag. It produces no header event and no payload.
- R9: Once set, the error flag stays high until reset. No further header or payload events occur.
- R10: A synchronous active-high reset clears the error flag and the memory of earlier type 1 headers. It returns the parser to searching for the sync pattern.
- R11: A byte is accepted only on a cycle with in_valid and in_ready both high. in_ready is high whenever the error flag is low, and low while it is high.
- R12: Addresses pass through unchanged, including undefined codes such as 0x0F. Defined codes include 0x02 (frame data in), 0x03 (frame data out) and 0x04 (command).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Incoming stream byte |
| in_valid | input | 1 | in_byte holds a byte |
| in_ready | output | 1 | Parser can take a byte |
| hdr_valid | output | 1 | One-cycle header event |
| hdr_is_t2 | output | 1 | Header was type 2 |
| hdr_op | output | 2 | Header opcode |
| hdr_addr | output | 5 | Register address for the packet |
| hdr_count | output | 27 | Payload word count of the packet |
| pay_valid | output | 1 | One-cycle payload word event |
| pay_addr | output | 5 | Register address of the payload word |
| pay_op | output | 2 | Opcode of the payload word |
| pay_data | output | 32 | Payload word |
| err | output | 1 | Sticky protocol error |

## Verification
The bench first feeds garbage, including a partial sync pattern and a no-op header word, before the real pattern. A parser that synchronized early or slid its window wrongly would emit spurious headers.

It then chains type 1 packets with zero and non-zero counts and two type 2 packets. The two type 2 packets follow type 1 headers with different addresses. A design that miscounted payload words would misread the following header. A design that latched the wrong address for type 2 would tag payload words with a stale register.

It finally drives an illegal type code, then resets. After the reset it sends a type 2 header first. A design that forgot to clear its type 1 memory would decode that type 2 header instead of flagging it. A design without a sticky error would resume emitting events.

// File: rtl/cfg_pkt_pkg.sv
package cfg_pkt_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int BPW      = WORD_W / BYTE_W;
    localparam int BCNT_W   = $clog2(BPW);
    localparam int ADDR_W   = 5;
    localparam int OP_W     = 2;
    localparam int KIND_W   = 3;
    localparam int CNT_W    = 27;
    localparam int T1CNT_W  = 11;

    localparam int KIND_LO  = WORD_W - KIND_W;
    localparam int OP_LO    = KIND_LO - OP_W;
    localparam int ADDR_LO  = 13;

    localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA995566;
    localparam logic [KIND_W-1:0] KIND_ONE  = 3'd1;
    localparam logic [KIND_W-1:0] KIND_TWO  = 3'd2;

    localparam logic [ADDR_W-1:0] REG_FRAME_IN  = 5'h02;
    localparam logic [ADDR_W-1:0] REG_FRAME_OUT = 5'h03;
    localparam logic [ADDR_W-1:0] REG_COMMAND   = 5'h04;

    typedef enum logic [1:0] {
        MODE_HDR = 2'd0,
        MODE_PAY = 2'd1,
        MODE_ERR = 2'd2
    } mode_e;
endpackage

// File: rtl/cfg_word_assembler.sv
module cfg_word_assembler
    import cfg_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              accept_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o
);
    typedef struct packed {
        logic              synced;
        logic [WORD_W-1:0] window;
        logic [BCNT_W-1:0] nbytes;
        logic [WORD_W-1:0] word;
        logic              word_valid;
    } asm_t;

    asm_t q, d;
    logic [WORD_W-1:0] win_next;

    assign win_next = {q.window[WORD_W-BYTE_W-1:0], byte_i};

    always_comb begin
        d = q;
        d.word_valid = 1'b0;
        if (accept_i) begin
            d.window = win_next;
            if (!q.synced) begin
                if (win_next == SYNC_WORD) begin
                    d.synced = 1'b1;
                    d.nbytes = '0;
                end
            end else begin
                d.nbytes = q.nbytes + 1'b1;
                if (q.nbytes == BCNT_W'(BPW - 1)) begin
                    d.word       = win_next;
                    d.word_valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign word_o       = q.word;
    assign word_valid_o = q.word_valid;

    assert_word_after_sync_R1: assert property (@(posedge clk) disable iff (rst)
        q.word_valid |-> q.synced);
    assert_sync_on_accept_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(q.synced) |-> $past(accept_i));
endmodule

// File: rtl/cfg_pkt_decoder.sv
module cfg_pkt_decoder
    import cfg_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_valid_i,
    output logic              hdr_valid_o,
    output logic              hdr_is_t2_o,
    output logic [OP_W-1:0]   hdr_op_o,
    output logic [ADDR_W-1:0] hdr_addr_o,
    output logic [CNT_W-1:0]  hdr_count_o,
    output logic              pay_valid_o,
    output logic [ADDR_W-1:0] pay_addr_o,
    output logic [OP_W-1:0]   pay_op_o,
    output logic [WORD_W-1:0] pay_data_o,
    output logic              err_o
);
    typedef struct packed {
        mode_e             mode;
        logic              t1_seen;
        logic [ADDR_W-1:0] last_addr;
        logic [ADDR_W-1:0] cur_addr;
        logic [OP_W-1:0]   cur_op;
        logic [CNT_W-1:0]  remain;
        logic              hdr_valid;
        logic              hdr_t2;
        logic [OP_W-1:0]   hdr_op;
        logic [ADDR_W-1:0] hdr_addr;
        logic [CNT_W-1:0]  hdr_cnt;
        logic              pay_valid;
        logic [ADDR_W-1:0] pay_addr;
        logic [OP_W-1:0]   pay_op;
        logic [WORD_W-1:0] pay_data;
    } dec_t;

    dec_t q, d;

    logic [KIND_W-1:0] f_kind;
    logic [OP_W-1:0]   f_op;
    logic [ADDR_W-1:0] f_addr;
    logic [CNT_W-1:0]  f_cnt1;
    logic [CNT_W-1:0]  f_cnt2;

    assign f_kind = word_i[WORD_W-1:KIND_LO];
    assign f_op   = word_i[KIND_LO-1:OP_LO];
    assign f_addr = word_i[ADDR_LO+ADDR_W-1:ADDR_LO];
    assign f_cnt1 = CNT_W'(word_i[T1CNT_W-1:0]);
    assign f_cnt2 = word_i[CNT_W-1:0];

    always_comb begin
        d = q;
        d.hdr_valid = 1'b0;
        d.pay_valid = 1'b0;
        if (word_valid_i) begin
            case (q.mode)
                MODE_HDR: begin
                    if (f_kind == KIND_ONE) begin
                        d.hdr_valid = 1'b1;
                        d.hdr_t2    = 1'b0;
                        d.hdr_op    = f_op;
                        d.hdr_addr  = f_addr;
                        d.hdr_cnt   = f_cnt1;
                        d.t1_seen   = 1'b1;
                        d.last_addr = f_addr;
                        d.cur_addr  = f_addr;
                        d.cur_op    = f_op;
                        d.remain    = f_cnt1;
                        d.mode      = (f_cnt1 != '0) ? MODE_PAY : MODE_HDR;
                    end else if (f_kind == KIND_TWO && q.t1_seen) begin
                        d.hdr_valid = 1'b1;
                        d.hdr_t2    = 1'b1;
                        d.hdr_op    = f_op;
                        d.hdr_addr  = q.last_addr;
                        d.hdr_cnt   = f_cnt2;
                        d.cur_addr  = q.last_addr;
                        d.cur_op    = f_op;
                        d.remain    = f_cnt2;
                        d.mode      = (f_cnt2 != '0) ? MODE_PAY : MODE_HDR;
                    end else begin
                        d.mode = MODE_ERR;
                    end
                end
                MODE_PAY: begin
                    d.pay_valid = 1'b1;
                    d.pay_addr  = q.cur_addr;
                    d.pay_op    = q.cur_op;
                    d.pay_data  = word_i;
                    d.remain    = q.remain - 1'b1;
                    if (q.remain == CNT_W'(1)) d.mode = MODE_HDR;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign hdr_valid_o = q.hdr_valid;
    assign hdr_is_t2_o = q.hdr_t2;
    assign hdr_op_o    = q.hdr_op;
    assign hdr_addr_o  = q.hdr_addr;
    assign hdr_count_o = q.hdr_cnt;
    assign pay_valid_o = q.pay_valid;
    assign pay_addr_o  = q.pay_addr;
    assign pay_op_o    = q.pay_op;
    assign pay_data_o  = q.pay_data;
    assign err_o       = (q.mode == MODE_ERR);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (q.mode == MODE_ERR) |=> (q.mode == MODE_ERR));
    assert_silent_in_err_R9: assert property (@(posedge clk) disable iff (rst)
        (q.mode == MODE_ERR) |-> (!q.hdr_valid && !q.pay_valid));
    assert_single_event_R5: assert property (@(posedge clk) disable iff (rst)
        !(q.hdr_valid && q.pay_valid));
    assert_pay_has_words_R5: assert property (@(posedge clk) disable iff (rst)
        (q.mode == MODE_PAY) |-> (q.remain != '0));
    assert_t2_after_t1_R8: assert property (@(posedge clk) disable iff (rst)
        (q.hdr_valid && q.hdr_t2) |-> q.t1_seen);
endmodule

// File: rtl/cfg_pkt_parser.sv
module cfg_pkt_parser
    import cfg_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              hdr_valid,
    output logic              hdr_is_t2,
    output logic [OP_W-1:0]   hdr_op,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic [CNT_W-1:0]  hdr_count,
    output logic              pay_valid,
    output logic [ADDR_W-1:0] pay_addr,
    output logic [OP_W-1:0]   pay_op,
    output logic [WORD_W-1:0] pay_data,
    output logic              err
);
    logic              accept;
    logic [WORD_W-1:0] word;
    logic              word_valid;

    assign in_ready = !err;
    assign accept   = in_valid && in_ready;

    cfg_word_assembler u_asm (
        .clk          (clk),
        .rst          (rst),
        .byte_i       (in_byte),
        .accept_i     (accept),
        .word_o       (word),
        .word_valid_o (word_valid)
    );

    cfg_pkt_decoder u_dec (
        .clk          (clk),
        .rst          (rst),
        .word_i       (word),
        .word_valid_i (word_valid),
        .hdr_valid_o  (hdr_valid),
        .hdr_is_t2_o  (hdr_is_t2),
        .hdr_op_o     (hdr_op),
        .hdr_addr_o   (hdr_addr),
        .hdr_count_o  (hdr_count),
        .pay_valid_o  (pay_valid),
        .pay_addr_o   (pay_addr),
        .pay_op_o     (pay_op),
        .pay_data_o   (pay_data),
        .err_o        (err)
    );

    assert_no_word_in_err_R11: assert property (@(posedge clk) disable iff (rst)
        (err && !word_valid) |=> !word_valid);
endmodule

// File: tb/cfg_pkt_parser_tb.sv
module cfg_pkt_parser_tb;
    import cfg_pkt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        in_byte = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              hdr_valid, hdr_is_t2, pay_valid, err;
    logic [1:0]        hdr_op, pay_op;
    logic [4:0]        hdr_addr, pay_addr;
    logic [26:0]       hdr_count;
    logic [31:0]       pay_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [34:0] hq[$];
    logic [38:0] pq[$];

    always #5 clk = ~clk;

    cfg_pkt_parser u_dut (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
        .hdr_valid(hdr_valid), .hdr_is_t2(hdr_is_t2), .hdr_op(hdr_op), .hdr_addr(hdr_addr),
        .hdr_count(hdr_count), .pay_valid(pay_valid), .pay_addr(pay_addr), .pay_op(pay_op),
        .pay_data(pay_data), .err(err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic exp_hdr(input logic t2, input logic [1:0] op, input logic [4:0] a, input logic [26:0] n);
        hq.push_back({t2, op, a, n});
    endtask

    task automatic exp_pay(input logic [4:0] a, input logic [1:0] op, input logic [31:0] w);
        pq.push_back({a, op, w});
    endtask

    task automatic send_word(input logic [31:0] w, input bit burst);
        for (int i = 3; i >= 0; i--) begin
            @(negedge clk);
            in_byte  = w[i*8 +: 8];
            in_valid = 1'b1;
            @(posedge clk);
            if (!burst) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (hdr_valid) begin
                if (hq.size() == 0) check("R1/R3/R8 unexpected header", {hdr_is_t2, hdr_op, hdr_addr, hdr_count}, 64'h0);
                else check("R4/R7 header fields", {hdr_is_t2, hdr_op, hdr_addr, hdr_count}, hq.pop_front());
            end
            if (pay_valid) begin
                if (pq.size() == 0) check("R5/R6/R8 unexpected payload", {pay_addr, pay_op, pay_data}, 64'h0);
                else check("R2/R5/R12 payload fields", {pay_addr, pay_op, pay_data}, pq.pop_front());
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R10 R11 reset state
        check("R10 err after reset", err, 0);
        check("R11 in_ready after reset", in_ready, 1);
        check("R10 no events after reset", {hdr_valid, pay_valid}, 0);

        // R1 garbage, partial sync, header-like word before sync
        send_word(32'h20000000, 1);
        send_word(32'hAA995500, 0);
        send_word(32'h30004003, 1);
        idle(3);
        check("R1 no error before sync", err, 0);
        send_word(32'h12AA9955, 0);
        @(negedge clk); in_byte = 8'h66; in_valid = 1'b1; @(posedge clk);
        @(negedge clk); in_valid = 1'b0;

        // R6 no-op
        exp_hdr(0, 0, 0, 0);
        send_word(32'h20000000, 1);
        // R4 R5 R2 type 1 write to frame data in, 3 words
        exp_hdr(0, 2, REG_FRAME_IN, 3);
        send_word(32'h30004003, 0);
        exp_pay(REG_FRAME_IN, 2, 32'h01020304); send_word(32'h01020304, 1);
        exp_pay(REG_FRAME_IN, 2, 32'hA5A55A5A); send_word(32'hA5A55A5A, 0);
        exp_pay(REG_FRAME_IN, 2, 32'hFFFFFFFF); send_word(32'hFFFFFFFF, 1);
        // R7 type 1 read with zero words, then type 2 with four
        exp_hdr(0, 1, REG_FRAME_OUT, 0);
        send_word(32'h28006000, 1);
        exp_hdr(1, 1, REG_FRAME_OUT, 4);
        send_word(32'h48000004, 1);
        for (int k = 0; k < 4; k++) begin
            exp_pay(REG_FRAME_OUT, 1, 32'h0A0B0C00 + k);
            send_word(32'h0A0B0C00 + k, k[0]);
        end
        // R12 undefined address 0x0F
        exp_hdr(0, 2, 5'h0F, 1);
        send_word(32'h3001E001, 1);
        exp_pay(5'h0F, 2, 32'h0BADF00D); send_word(32'h0BADF00D, 1);
        // R7 inherits the latest type 1 address (command)
        exp_hdr(0, 2, REG_COMMAND, 1);
        send_word(32'h30008001, 1);
        exp_pay(REG_COMMAND, 2, 32'h00000007); send_word(32'h00000007, 1);
        exp_hdr(1, 2, REG_COMMAND, 2);
        send_word(32'h50000002, 0);
        exp_pay(REG_COMMAND, 2, 32'h11111111); send_word(32'h11111111, 1);
        exp_pay(REG_COMMAND, 2, 32'h22222222); send_word(32'h22222222, 1);
        idle(3);
        check("R5 all expected headers seen", hq.size(), 0);
        check("R5 all expected payload seen", pq.size(), 0);
        check("R3 no error on legal stream", err, 0);

        // R3 R9 illegal type 3
        send_word(32'h60000000, 1);
        idle(2);
        check("R3 error on type 3", err, 1);
        check("R11 ready low in error", in_ready, 0);
        send_word(32'h20000000, 1);
        send_word(32'h20000001, 1);
        idle(3);
        check("R9 error stays set", err, 1);

        // R10 reset, resync needed, type 1 memory cleared
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R10 error cleared by reset", err, 0);
        check("R11 ready back after reset", in_ready, 1);
        send_word(32'h60000000, 1);
        idle(2);
        check("R10 R1 unsynced after reset", err, 0);
        send_word(SYNC_WORD, 1);
        send_word(32'h48000004, 1);
        send_word(32'h01010101, 1);
        idle(3);
        check("R8 type 2 before type 1 errors", err, 1);
        check("R8 no stray events", hq.size() + pq.size(), 0);
        finish_run();
    end
endmodule